// File: doc/BRIEF.md
# Parity-Gated Update Filter Register

This block holds the most recently accepted measurement word and decides, on each latch strobe, whether a newly offered sample may replace it. A sample produced by counting an asynchronous signal against a local clock can wander by one count even when the quantity being measured is steady. The block suppresses that wander by accepting a new sample only when it differs from the held word by an even amount. That holds exactly when the two least significant bits agree.

A sticky primed flag starts at zero after reset. The first strobe after reset loads its sample whatever its parity and sets the flag on the same edge. Every later strobe is filtered. The flag also tells downstream logic that the held word carries a real measurement.

Top module: `parity_update_filter`

## Requirements
- R1: Asserting rst_ni (active low, asynchronous) forces held_o to zero and primed_o to 0 at once, and they stay there while reset is asserted.
- R2: While primed_o is 0, a clock edge with latch_i high loads sample_i into held_o whatever its bit 0 is, and sets primed_o to 1 on that same edge.
- R3: Once primed_o is 1, it stays 1 on every edge until the next reset, whether or not a strobe arrives.
- R4: While primed_o is 1, a clock edge with latch_i high and sample_i[0] equal to held_o[0] loads sample_i into held_o. This covers changes of zero, two and any other even amount.
- R5: While primed_o is 1, a clock edge with latch_i high and sample_i[0] different from held_o[0] leaves held_o unchanged. This covers a change of one and any other odd amount.
- R6: A clock edge with latch_i low leaves held_o and primed_o unchanged, whatever sample_i carries.
- R7: After a reset in mid-operation, the next strobe is again loaded without the parity test, even if its bit 0 differs from the zero held word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | DATA_W (10) | Candidate measurement word |
| latch_i | input | 1 | Strobe offering sample_i for loading |
| held_o | output | DATA_W (10) | Last accepted measurement |
| primed_o | output | 1 | High once a first sample has been accepted since reset |

## Verification
On every cycle, the assertions check the load and reject decisions: an unconditional first load that also sets the flag, a load on a matching bit 0, a stable word on a mismatched bit 0, and no change without a strobe. They also check that the flag is sticky. The asynchronous clearing of both outputs while reset is held, and the reopening of the bypass after a mid-run reset, can only be shown by the bench's scenarios. The same holds for multi-step sequences in which an odd step is rejected and a later even step relative to the held word is accepted.

// File: rtl/puf_pkg.sv
package puf_pkg;
  localparam int unsigned DEF_DATA_W = 10;
endpackage

// File: rtl/puf_accept_gate.sv
module puf_accept_gate (
  input  logic latch_i,
  input  logic primed_i,
  input  logic sample_lsb_i,
  input  logic held_lsb_i,
  output logic accept_o
);
  logic parity_match;

  always_comb begin
    parity_match = ~(sample_lsb_i ^ held_lsb_i);
    accept_o     = latch_i & (~primed_i | parity_match);
  end
endmodule

// File: rtl/puf_hold_reg.sv
module puf_hold_reg #(
  parameter int unsigned DATA_W = puf_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/puf_prime_flag.sv
module puf_prime_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |=> flag_o); // R3
endmodule

// File: rtl/parity_update_filter.sv
module parity_update_filter #(
  parameter int unsigned DATA_W = puf_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              latch_i,
  output logic [DATA_W-1:0] held_o,
  output logic              primed_o
);
  logic accept;

  puf_accept_gate u_gate (
    .latch_i      (latch_i),
    .primed_i     (primed_o),
    .sample_lsb_i (sample_i[0]),
    .held_lsb_i   (held_o[0]),
    .accept_o     (accept)
  );

  puf_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .d_i    (sample_i),
    .q_o    (held_o)
  );

  // first acceptance primes the filter
  puf_prime_flag u_prime (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (accept),
    .flag_o (primed_o)
  );

  AST_FIRST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && !primed_o) |=> (primed_o && held_o == $past(sample_i))); // R2

  AST_EVEN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && primed_o && sample_i[0] == held_o[0]) |=> (held_o == $past(sample_i))); // R4

  AST_ODD_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && primed_o && sample_i[0] != held_o[0]) |=> $stable(held_o)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> ($stable(held_o) && $stable(primed_o))); // R6
endmodule

// File: tb/parity_update_filter_bench.sv
`timescale 1ns/1ps
module parity_update_filter_bench;
  localparam int unsigned W = 10;
  localparam int NV = 12;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] sample_i = '0;
  logic         latch_i = 1'b0;
  logic [W-1:0] held_o;
  logic         primed_o;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk_i = ~clk_i;

  parity_update_filter #(.DATA_W(W)) u_parity_update_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_i),
    .latch_i  (latch_i),
    .held_o   (held_o),
    .primed_o (primed_o)
  );

  // {latch, sample, expected held, expected primed}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 10'h3FF, 10'h000, 1'b0}, // R6 idle before first load
    {1'b1, 10'h12D, 10'h12D, 1'b1}, // R2 first load, odd vs held 0
    {1'b1, 10'h12E, 10'h12D, 1'b1}, // R5 +1 rejected
    {1'b1, 10'h12F, 10'h12F, 1'b1}, // R4 +2 accepted
    {1'b1, 10'h12F, 10'h12F, 1'b1}, // R4 zero change
    {1'b1, 10'h12C, 10'h12F, 1'b1}, // R5 -3 rejected
    {1'b0, 10'h000, 10'h12F, 1'b1}, // R6 no strobe
    {1'b1, 10'h001, 10'h001, 1'b1}, // R4 large even step
    {1'b1, 10'h3FE, 10'h001, 1'b1}, // R5 odd step
    {1'b1, 10'h3FF, 10'h3FF, 1'b1}, // R4 to full scale
    {1'b1, 10'h000, 10'h3FF, 1'b1}, // R5 odd step down
    {1'b0, 10'h3FE, 10'h3FF, 1'b1}  // R3 flag persists
  };
  localparam int VREQ [NV] = '{6, 2, 5, 4, 4, 5, 6, 4, 5, 4, 5, 3};

  task automatic check(input int req, input logic [W-1:0] exp_h, input logic exp_p);
    compared++;
    if (held_o !== exp_h || primed_o !== exp_p) begin
      mismatched++;
      $display("FAIL R%0d: held=%h primed=%b expected held=%h primed=%b",
               req, held_o, primed_o, exp_h, exp_p);
    end
  endtask

  task automatic step(input logic l, input logic [W-1:0] s);
    @(negedge clk_i);
    latch_i  = l;
    sample_i = s;
    @(negedge clk_i);
    latch_i  = 1'b0;
  endtask

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(1, '0, 1'b0); // R1 state during reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, '0, 1'b0); // R1 state after release

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      latch_i  = VEC[i][21];
      sample_i = VEC[i][20:11];
      @(negedge clk_i);
      latch_i  = 1'b0;
      check(VREQ[i], VEC[i][10:1], VEC[i][0]);
    end

    // R3: idle cycles keep the flag
    repeat (5) @(negedge clk_i);
    check(3, 10'h3FF, 1'b1);

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5 check(1, '0, 1'b0);
    repeat (2) @(negedge clk_i);
    check(1, '0, 1'b0);
    rst_ni = 1'b1;

    // R6: strobe-free cycle with odd sample changes nothing
    step(1'b0, 10'h155);
    check(6, '0, 1'b0);

    // R7: bypass reopens, odd sample over held zero
    step(1'b1, 10'h155);
    check(7, 10'h155, 1'b1);

    // R5 then R4 after re-prime
    step(1'b1, 10'h154);
    check(5, 10'h155, 1'b1);
    step(1'b1, 10'h153);
    check(4, 10'h153, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule